// File: doc/BRIEF.md
# Conversion Start and Busy Controller

This block is the timing controller in front of a successive-approximation converter. It accepts a conversion request from either of two sources: a rising edge on an external start pin, or a register write that carries a start bit. On an accepted request it puts the sampling stage into hold and raises busy. It then waits for the next falling edge of the converter's master clock and keeps busy high for a fixed number of master-clock half periods. When busy drops, the software start bit clears and a one-cycle done pulse marks the point at which the result can be read.

The block runs on a fast clock `clk_i` at twice the master-clock rate. It generates the master clock itself as `mclk_o`, so every half period is one fast cycle. A request that lands on a fast edge where the master clock falls has missed its setup window. Its conversion then starts one full master period later. The first request accepted after reset starts a self-calibration window of a separate, longer length. A short acquisition window follows every conversion. Requests that arrive during a conversion or during that acquisition window are dropped.

Top module: `conv_start_ctrl`

## Requirements
- R1: After reset, `busy_o`, `hold_o`, `cal_o`, `sw_start_o`, `done_o` and `mclk_o` are all 0.
- R2: A request is a rising edge of `conv_pin_i` (pin low on the previous `clk_i` edge and high on this one) or a cycle with `reg_wr_i`=1 and `reg_start_i`=1. When the block is idle, a request sampled on edge E drives `busy_o` and `hold_o` to 1 after E. `sw_start_o` then reads 1 only if the request included a register write with the start bit.
- R3: `mclk_o` toggles on every `clk_i` edge, starting from 0 after reset. A master falling edge is a `clk_i` edge at which `mclk_o` was 1 just before the edge. The conversion window starts on the first master falling edge after E.
- R4: For a normal conversion, `busy_o` stays high for CONV_HALF+1 `clk_i` cycles if `mclk_o` was 0 just before E (setup met). It stays high for CONV_HALF+2 cycles if `mclk_o` was 1 (setup missed, one extra master period).
- R5: The first accepted request after reset is a calibration. `cal_o` is high for the whole busy window, which lasts CAL_HALF+1 cycles (setup met) or CAL_HALF+2 cycles (setup missed).
- R6: Every later accepted request is a normal conversion, with `cal_o` staying 0.
- R7: When `busy_o` falls, `sw_start_o` clears to 0 in the same cycle. `done_o` is 1 for exactly that one cycle.
- R8: Requests of either kind while `busy_o` is high are ignored. They neither change the busy length nor set `sw_start_o`.
- R9: Requests sampled on the ACQ_HALF `clk_i` edges following the edge at which `busy_o` fell are ignored. A request sampled on any later edge is accepted.
- R10: A pin edge and a start-bit write sampled on the same edge start exactly one conversion, with `sw_start_o`=1.
- R11: `hold_o` equals `busy_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock at twice the master-clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_pin_i | input | 1 | External start pin, synchronous to `clk_i`, acts on rising edge |
| reg_wr_i | input | 1 | Control-register write strobe, one cycle per write |
| reg_start_i | input | 1 | Start bit carried by the register write |
| mclk_o | output | 1 | Generated master clock |
| sw_start_o | output | 1 | Software start bit as held in the control register |
| hold_o | output | 1 | Track/hold in hold mode |
| busy_o | output | 1 | Conversion or calibration in progress |
| cal_o | output | 1 | Current busy window is the self-calibration |
| done_o | output | 1 | One-cycle pulse when busy falls |

## Verification
The bound assertions check several properties on every cycle:
- the master clock toggles on every edge;
- `hold_o` tracks `busy_o`;
- `cal_o` only appears inside busy, and only once;
- the start bit clears and `done_o` pulses at the busy fall;
- busy only rises after a request;
- busy never restarts inside the acquisition window;
- every busy window length lies between the normal and calibration bounds.

The exact window length for a given master-clock phase at the request needs the bench's scenarios, as do the one-time calibration length and the fact that pokes during busy or acquisition leave no trace. The bench forces setup-met and setup-missed phases, randomises the gaps, and computes each expected length from the phase it observed.

// File: rtl/conv_start_pkg.sv
package conv_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2,
    ST_ACQ  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/conv_phase_gen.sv
module conv_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mclk_o,
  output logic fall_edge_o
);
  logic mclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mclk_q <= 1'b0;
    else         mclk_q <= ~mclk_q;
  end

  assign mclk_o      = mclk_q;
  // the current edge takes mclk high->low
  assign fall_edge_o = mclk_q;
endmodule

// File: rtl/conv_req_detect.sv
module conv_req_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic wr_i,
  input  logic wr_start_i,
  input  logic idle_i,
  input  logic busy_fall_i,
  output logic req_o,
  output logic sw_start_o
);
  logic pin_q;
  logic sw_q;
  logic pin_rise;
  logic sw_req;

  assign pin_rise = pin_i & ~pin_q;
  assign sw_req   = wr_i & wr_start_i;
  assign req_o    = pin_rise | sw_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (busy_fall_i)           sw_q <= 1'b0;
      else if (sw_req && idle_i) sw_q <= 1'b1;
    end
  end

  assign sw_start_o = sw_q;
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_start_pkg::*;
#(
  parameter int CONV_HALF = 33,
  parameter int CAL_HALF  = 80,
  parameter int ACQ_HALF  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fall_edge_i,
  output logic idle_o,
  output logic busy_o,
  output logic busy_fall_o,
  output logic cal_o,
  output logic done_o
);
  localparam int MAX_A = (CAL_HALF > CONV_HALF) ? CAL_HALF : CONV_HALF;
  localparam int MAX_H = (MAX_A > ACQ_HALF) ? MAX_A : ACQ_HALF;
  localparam int CW    = $clog2(MAX_H + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          cal_q;
  logic          cal_used_q;
  logic          done_q;
  logic [CW-1:0] conv_load;

  assign conv_load   = cal_q ? CW'(CAL_HALF - 1) : CW'(CONV_HALF - 1);
  assign busy_fall_o = (state_q == ST_CONV) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      cal_q      <= 1'b0;
      cal_used_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= busy_fall_o;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_ARM;
          if (!cal_used_q) begin
            cal_q      <= 1'b1;
            cal_used_q <= 1'b1;
          end
        end
        ST_ARM: if (fall_edge_i) begin
          state_q <= ST_CONV;
          cnt_q   <= conv_load;
        end
        ST_CONV: begin
          if (cnt_q == '0) begin
            state_q <= ST_ACQ;
            cal_q   <= 1'b0;
            cnt_q   <= CW'(ACQ_HALF - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACQ: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign busy_o = (state_q == ST_ARM) || (state_q == ST_CONV);
  assign cal_o  = cal_q;
  assign done_o = done_q;
endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl #(
  parameter int CONV_HALF = 33,
  parameter int CAL_HALF  = 80,
  parameter int ACQ_HALF  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_pin_i,
  input  logic reg_wr_i,
  input  logic reg_start_i,
  output logic mclk_o,
  output logic sw_start_o,
  output logic hold_o,
  output logic busy_o,
  output logic cal_o,
  output logic done_o
);
  logic fall_edge;
  logic req;
  logic idle;
  logic busy;
  logic busy_fall;

  conv_phase_gen u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mclk_o      (mclk_o),
    .fall_edge_o (fall_edge)
  );

  conv_req_detect u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (conv_pin_i),
    .wr_i        (reg_wr_i),
    .wr_start_i  (reg_start_i),
    .idle_i      (idle),
    .busy_fall_i (busy_fall),
    .req_o       (req),
    .sw_start_o  (sw_start_o)
  );

  conv_seq_fsm #(
    .CONV_HALF (CONV_HALF),
    .CAL_HALF  (CAL_HALF),
    .ACQ_HALF  (ACQ_HALF)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .fall_edge_i (fall_edge),
    .idle_o      (idle),
    .busy_o      (busy),
    .busy_fall_o (busy_fall),
    .cal_o       (cal_o),
    .done_o      (done_o)
  );

  assign busy_o = busy;
  assign hold_o = busy;
endmodule

// File: rtl/conv_start_ctrl_chk.sv
module conv_start_ctrl_chk #(
  parameter int CONV_HALF = 33,
  parameter int CAL_HALF  = 80,
  parameter int ACQ_HALF  = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_pin_i,
  input logic reg_wr_i,
  input logic reg_start_i,
  input logic mclk_o,
  input logic sw_start_o,
  input logic hold_o,
  input logic busy_o,
  input logic cal_o,
  input logic done_o
);
  int  busy_cnt;
  int  low_cnt;
  logic cal_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt   <= 0;
      low_cnt    <= ACQ_HALF + 1;
      cal_seen_q <= 1'b0;
    end else begin
      busy_cnt <= busy_o ? busy_cnt + 1 : 0;
      if (busy_o)                  low_cnt <= 0;
      else if (low_cnt <= ACQ_HALF) low_cnt <= low_cnt + 1;
      if (cal_o && !busy_o) cal_seen_q <= 1'b1;
      else if ($fell(cal_o)) cal_seen_q <= 1'b1;
    end
  end

  AST_MCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mclk_o != $past(mclk_o))); // R3
  AST_HOLD_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o == busy_o); // R11
  AST_CAL_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> busy_o); // R5
  AST_CAL_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_seen_q |-> !cal_o); // R6
  AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!sw_start_o && done_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_RISE_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(reg_wr_i && reg_start_i) || $past(conv_pin_i))); // R2
  AST_ACQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (low_cnt > ACQ_HALF)); // R9
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt >= CONV_HALF + 1 && busy_cnt <= CAL_HALF + 2)); // R4
endmodule

bind conv_start_ctrl conv_start_ctrl_chk #(
  .CONV_HALF (CONV_HALF),
  .CAL_HALF  (CAL_HALF),
  .ACQ_HALF  (ACQ_HALF)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_pin_i  (conv_pin_i),
  .reg_wr_i    (reg_wr_i),
  .reg_start_i (reg_start_i),
  .mclk_o      (mclk_o),
  .sw_start_o  (sw_start_o),
  .hold_o      (hold_o),
  .busy_o      (busy_o),
  .cal_o       (cal_o),
  .done_o      (done_o)
);

// File: tb/sim_conv_start_ctrl.sv
`timescale 1ns/1ps
module sim_conv_start_ctrl;
  localparam int CONV_HALF = 33;
  localparam int CAL_HALF  = 80;
  localparam int ACQ_HALF  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, wr = 1'b0, wr_start = 1'b0;
  logic mclk, sw_start, hold, busy, cal, done;

  int n_chk = 0;
  int n_err = 0;
  bit first_conv = 1'b1;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_start_ctrl #(.CONV_HALF(CONV_HALF), .CAL_HALF(CAL_HALF), .ACQ_HALF(ACQ_HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_pin_i(pin), .reg_wr_i(wr), .reg_start_i(wr_start),
    .mclk_o(mclk), .sw_start_o(sw_start), .hold_o(hold), .busy_o(busy),
    .cal_o(cal), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input bit is_cal, input bit missed);
    return (is_cal ? CAL_HALF : CONV_HALF) + (missed ? 2 : 1);
  endfunction

  // kind: 0 pin, 1 write, 2 both
  task automatic do_conv(input int kind, input bit force_ph, input bit want_missed,
                         input bit poke, input bit acq_poke);
    bit missed;
    int n;
    int e;
    bit exp_sw;
    if (force_ph) while (mclk !== want_missed) @(negedge clk);
    missed = mclk;
    e = exp_len(first_conv, missed);
    exp_sw = (kind != 0);
    if (kind != 1) pin = 1'b1;
    if (kind != 0) begin wr = 1'b1; wr_start = 1'b1; end
    @(negedge clk);
    wr = 1'b0; wr_start = 1'b0;
    chk(busy === 1'b1, "R2 busy rise", busy, 1);
    chk(hold === 1'b1, "R2 hold rise", hold, 1);
    chk(sw_start === exp_sw, (kind == 2) ? "R10 sw bit" : "R2 sw bit", sw_start, exp_sw);
    chk(cal === first_conv, first_conv ? "R5 cal flag" : "R6 no cal", cal, first_conv);
    n = 1;
    while (n < 500) begin
      if (n == 2) pin = 1'b0;
      if (poke && n == 6) begin pin = 1'b1; wr = 1'b1; wr_start = 1'b1; end
      if (poke && n == 7) begin
        wr = 1'b0; wr_start = 1'b0;
        chk(sw_start === exp_sw, "R8 sw unchanged in busy", sw_start, exp_sw);
      end
      if (poke && n == 8) pin = 1'b0;
      @(negedge clk);
      if (busy !== 1'b1) break;
      if (hold !== busy) chk(1'b0, "R11 hold", hold, busy);
      n++;
    end
    chk(n == e, first_conv ? (missed ? "R5 cal len missed" : "R5 cal len met")
                           : (poke ? "R8 len with poke" : (missed ? "R4 len missed" : "R4 len met")),
        n, e);
    chk(sw_start === 1'b0, "R7 sw cleared", sw_start, 0);
    chk(done === 1'b1, "R7 done pulse", done, 1);
    chk(cal === 1'b0, "R6 cal low after", cal, 0);
    first_conv = 1'b0;
    if (acq_poke) begin
      pin = 1'b1;          // seen on first edge after fall
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", done, 0);
      repeat (4) begin
        @(negedge clk);
        chk(busy === 1'b0, "R9 ignored in acq", busy, 0);
      end
      pin = 1'b0;
      @(negedge clk);
    end else begin
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", done, 0);
      repeat (ACQ_HALF - 1) @(negedge clk);
    end
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 150000) begin @(posedge clk); wd++; end
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(busy === 0 && hold === 0 && cal === 0, "R1 outputs idle", busy, 0);
    chk(sw_start === 0 && done === 0 && mclk === 0, "R1 regs clear", sw_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mclk === 1'b1, "R3 mclk toggles", mclk, 1);
    @(negedge clk);
    chk(mclk === 1'b0, "R3 mclk toggles back", mclk, 0);
    chk(busy === 1'b0, "R1 idle after reset", busy, 0);

    do_conv(0, 1'b1, 1'b0, 1'b0, 1'b0);   // calibration, setup met
    do_conv(1, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 met
    do_conv(1, 1'b1, 1'b1, 1'b0, 1'b0);   // R4 missed
    do_conv(0, 1'b1, 1'b1, 1'b1, 1'b0);   // R8 pokes during busy
    do_conv(2, 1'b0, 1'b0, 1'b0, 1'b1);   // R10 both, R9 acq poke
    do_conv(1, 1'b0, 1'b0, 1'b0, 1'b0);   // R9 accepted right after acq

    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = $urandom_range(0, 5);
      repeat (gap) @(negedge clk);
      do_conv($urandom_range(0, 2), 1'b0, 1'b0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    end

    // write with start bit low has no effect
    wr = 1'b1; wr_start = 1'b0;
    @(negedge clk);
    wr = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(busy === 1'b0 && sw_start === 1'b0, "R2 no start without bit", busy, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule